// File: doc/BRIEF.md
# Programmable TDM Input Bit-Delay Sampler

This block takes one serial time-division-multiplexed input and picks each bit off the line at a programmable instant. It runs on a clock at four times the bit rate, so every bit period holds four clock cycles, called quarters. A one-cycle frame pulse marks quarter 0 of bit 0. A 5-bit delay code and a mode input set the sampling instant. In quarter mode the code is a delay in quarter-bit steps, added to a default sampling point three quarters into the bit. In split mode the upper three code bits give a whole-bit delay and the lower two bits choose which quarter of the bit is sampled.

Each sampled bit is presented on `bit_out` together with a one-cycle `bit_valid` strobe and its index within the frame. The mode and the code are read only in the cycle that carries the frame pulse, so one frame is always sampled with one setting. Between frame pulses the quarter count runs freely, modulo the frame length. As a result, bits whose sampling instant falls past the end of the frame are still delivered after the count wraps. The frame length in bits is the parameter `FRAME_BITS` and must be at least 16.

Top module: `tdm_bit_sampler`

## Requirements
- R1: While reset is active, and after it until a frame pulse has been seen, `bit_valid`, `bit_out` and `bit_index` are 0. The first valid bit after reset carries index 0.
- R2: With `mode_split`=0, bit k is sampled in cycle 3+code+4k, counted from the frame-pulse cycle as cycle 0. Code 0 therefore samples three quarters into each bit, and code 31 samples at quarter 34.
- R3: With `mode_split`=0 and code 19 (10011b), bit k is sampled at quarter 22+4k, a delay of 4 3/4 bit periods past the default point.
- R4: With `mode_split`=1, bit k is sampled at quarter 4·code[4:2] + code[1:0] + 1 + 4k. Code[1:0] values 0, 1, 2 and 3 select the points 1/4, 2/4, 3/4 and 4/4 of the bit. Code[4:2] adds 0 to 7 whole bits.
- R5: Outputs are registered. A bit sampled in cycle c is shown in cycle c+1 with `bit_index` = k mod `FRAME_BITS`, so the index after `FRAME_BITS`-1 is 0.
- R6: `bit_valid` is high for one cycle per sampled bit. When no frame pulse falls between two strobes, they are exactly four cycles apart.
- R7: A change of `delay_code` or `mode_split` between frame pulses does not alter the sampling schedule. The new setting applies from the next frame pulse.
- R8: With no further frame pulse, the quarter count wraps at 4·`FRAME_BITS` and sampling continues. Bits whose instant lies past the frame end are taken after the wrap, with the `ser_in` value of that cycle.
- R9: A frame pulse arriving at any point restarts the quarter count at 0 and applies the setting present in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle marker of quarter 0 of bit 0 |
| ser_in | input | 1 | Serial TDM input |
| mode_split | input | 1 | 0: quarter-step delay; 1: whole-bit delay plus phase |
| delay_code | input | 5 | Delay code, read in the frame-pulse cycle |
| bit_out | output | 1 | Sampled bit |
| bit_valid | output | 1 | One-cycle strobe marking a new sampled bit |
| bit_index | output | $clog2(FRAME_BITS) | Index of the sampled bit within its frame |

## Verification
The hardest situations to reach are the ones that straddle a frame boundary. These are bits whose sampling instant lies past the frame end, a frame pulse that cuts a frame short, and a code change in the middle of a frame. The bench drives `ser_in` with a value that changes pseudo-randomly every quarter, so a sample taken one quarter early or late returns the wrong value. Each scenario then follows the pulse with more than a full frame without a new pulse, so the tail bits are taken after the wrap. In some runs the code is changed mid-frame, and in others a pulse is fired after only a partial frame.

// File: rtl/tdm_smp_pkg.sv
package tdm_smp_pkg;

    localparam int CODE_W = 5;
    localparam int OFFS_W = 6;
    localparam int QUARTERS_PER_BIT = 4;

    typedef enum logic {
        MODE_QUARTER = 1'b0,
        MODE_SPLIT   = 1'b1
    } smp_mode_e;

    typedef struct packed {
        logic [2:0] whole;
        logic [1:0] phase;
    } delay_code_t;

    // quarter offset of bit 0's sampling instant from the frame-pulse cycle
    function automatic logic [OFFS_W-1:0] calc_offset(smp_mode_e mode, delay_code_t code);
        logic [OFFS_W-1:0] offs;
        if (mode == MODE_QUARTER) begin
            offs = OFFS_W'(3) + {1'b0, code};
        end else begin
            offs = {1'b0, code.whole, 2'b00} + {4'b0000, code.phase} + OFFS_W'(1);
        end
        return offs;
    endfunction

endpackage

// File: rtl/tdm_phase_ctr.sv
module tdm_phase_ctr #(
    parameter int FRAME_Q = 1024,
    localparam int QW = $clog2(FRAME_Q)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_pulse,
    output logic [QW-1:0] qnow,
    output logic          seen_fp
);

    logic [QW-1:0] qcnt_r;

    assign qnow = frame_pulse ? '0 : qcnt_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt_r  <= '0;
            seen_fp <= 1'b0;
        end else begin
            qcnt_r <= (qnow == QW'(FRAME_Q - 1)) ? '0 : qnow + QW'(1);
            if (frame_pulse) begin
                seen_fp <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_offset_sel.sv
module tdm_offset_sel
    import tdm_smp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_pulse,
    input  logic                 mode_split,
    input  logic [CODE_W-1:0]    delay_code,
    output logic [OFFS_W-1:0]    offs_now
);

    logic [OFFS_W-1:0] offs_r;
    logic [OFFS_W-1:0] offs_new;

    assign offs_new = calc_offset(smp_mode_e'(mode_split), delay_code_t'(delay_code));
    assign offs_now = frame_pulse ? offs_new : offs_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            offs_r <= calc_offset(MODE_QUARTER, '0);
        end else begin
            offs_r <= offs_now;
        end
    end

endmodule

// File: rtl/tdm_sample_strobe.sv
module tdm_sample_strobe
    import tdm_smp_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    localparam int FRAME_Q = FRAME_BITS * QUARTERS_PER_BIT,
    localparam int QW = $clog2(FRAME_Q),
    localparam int IDX_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [QW-1:0]     qnow,
    input  logic [OFFS_W-1:0] offs_now,
    input  logic              seen_fp,
    input  logic              ser_in,
    output logic              bit_out,
    output logic              bit_valid,
    output logic [IDX_W-1:0]  bit_index
);

    logic [QW-1:0]    offs_ext;
    logic [QW-1:0]    diff;
    logic             strobe;
    logic             emit;
    logic [IDX_W-1:0] idx;
    logic             synced_r;

    assign offs_ext = QW'(offs_now);

    // distance from bit 0's instant, modulo the frame length in quarters
    generate
        if ((FRAME_Q & (FRAME_Q - 1)) == 0) begin : g_pow2
            assign diff = qnow - offs_ext;
        end else begin : g_general
            assign diff = (qnow >= offs_ext) ? (qnow - offs_ext)
                                             : (qnow + QW'(FRAME_Q) - offs_ext);
        end
    endgenerate

    assign strobe = (diff[1:0] == 2'b00);
    assign idx    = diff[QW-1:2];
    assign emit   = strobe && seen_fp && (synced_r || (idx == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            synced_r  <= 1'b0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            bit_index <= '0;
        end else begin
            bit_valid <= emit;
            if (emit) begin
                synced_r  <= 1'b1;
                bit_out   <= ser_in;
                bit_index <= idx;
            end
        end
    end

endmodule

// File: rtl/tdm_bit_sampler.sv
module tdm_bit_sampler
    import tdm_smp_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_pulse,
    input  logic                          ser_in,
    input  logic                          mode_split,
    input  logic [4:0]                    delay_code,
    output logic                          bit_out,
    output logic                          bit_valid,
    output logic [$clog2(FRAME_BITS)-1:0] bit_index
);

    localparam int FRAME_Q = FRAME_BITS * QUARTERS_PER_BIT;
    localparam int QW      = $clog2(FRAME_Q);

    logic [QW-1:0]     qnow;
    logic              seen_fp;
    logic [OFFS_W-1:0] offs_now;

    tdm_phase_ctr #(.FRAME_Q(FRAME_Q)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .qnow        (qnow),
        .seen_fp     (seen_fp)
    );

    tdm_offset_sel u_offs (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .mode_split  (mode_split),
        .delay_code  (delay_code),
        .offs_now    (offs_now)
    );

    tdm_sample_strobe #(.FRAME_BITS(FRAME_BITS)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .qnow      (qnow),
        .offs_now  (offs_now),
        .seen_fp   (seen_fp),
        .ser_in    (ser_in),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .bit_index (bit_index)
    );

endmodule

// File: rtl/tdm_bit_sampler_chk.sv
module tdm_bit_sampler_chk #(
    parameter int FRAME_BITS = 256,
    localparam int IDX_W = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_pulse,
    input logic             mode_split,
    input logic [4:0]       delay_code,
    input logic             bit_valid,
    input logic [IDX_W-1:0] bit_index
);

    logic seen_fp_c;
    logic had_valid_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_fp_c   <= 1'b0;
            had_valid_c <= 1'b0;
        end else begin
            if (frame_pulse) seen_fp_c <= 1'b1;
            if (bit_valid)   had_valid_c <= 1'b1;
        end
    end

    // R1
    no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_fp_c |-> !bit_valid);

    // R1
    first_index_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !had_valid_c) |-> (bit_index == '0));

    // R2
    quarter_default_point_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && !mode_split && delay_code == 5'd0) |-> ##4 (bit_valid && bit_index == '0));

    // R4
    split_first_quarter_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && mode_split && delay_code == 5'd0) |-> ##2 (bit_valid && bit_index == '0));

    // R6
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !$past(frame_pulse, 1) && !$past(frame_pulse, 2) && !$past(frame_pulse, 3))
        |-> (!$past(bit_valid, 1) && !$past(bit_valid, 2) && !$past(bit_valid, 3)));

    // R5
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && $past(bit_valid, 4) && !$past(frame_pulse, 1) && !$past(frame_pulse, 2)
         && !$past(frame_pulse, 3) && !$past(frame_pulse, 4))
        |-> (($past(bit_index, 4) == IDX_W'(FRAME_BITS - 1)) ? (bit_index == '0)
                                                            : (bit_index == $past(bit_index, 4) + IDX_W'(1))));

endmodule

bind tdm_bit_sampler tdm_bit_sampler_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_pulse (frame_pulse),
    .mode_split  (mode_split),
    .delay_code  (delay_code),
    .bit_valid   (bit_valid),
    .bit_index   (bit_index)
);

// File: tb/tdm_bit_sampler_tb.sv
module tdm_bit_sampler_tb;

    localparam int CLK_P = 10;
    localparam int NB    = 16;
    localparam int NQ    = 4 * NB;
    localparam int IW    = $clog2(NB);

    logic          clk;
    logic          rst;
    logic          frame_pulse;
    logic          ser_in;
    logic          mode_split;
    logic [4:0]    delay_code;
    logic          bit_out;
    logic          bit_valid;
    logic [IW-1:0] bit_index;

    int n_chk = 0;
    int n_err = 0;
    int acyc  = 0;
    int fp_req_n = 0;
    int fp_ack_n = 0;

    tdm_bit_sampler #(.FRAME_BITS(NB)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .ser_in      (ser_in),
        .mode_split  (mode_split),
        .delay_code  (delay_code),
        .bit_out     (bit_out),
        .bit_valid   (bit_valid),
        .bit_index   (bit_index)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_P/2) clk = ~clk;
    end

    // pseudo-random line value per cycle, changing every quarter
    function automatic bit line_val(int a);
        int unsigned h;
        h = int'(a) * 32'h9E3779B1;
        return ^h[31:20];
    endfunction

    function automatic int exp_offset(bit md, int code);
        if (md) return 4 * (code / 4) + (code % 4) + 1;
        return 3 + code;
    endfunction

    // line and frame-pulse driver
    initial begin
        ser_in = 1'b0;
        frame_pulse = 1'b0;
        forever begin
            @(negedge clk);
            acyc = acyc + 1;
            ser_in = line_val(acyc);
            if (fp_req_n != fp_ack_n) begin
                frame_pulse = 1'b1;
                fp_ack_n = fp_req_n;
            end else begin
                frame_pulse = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, acyc);
        end
    endtask

    // Fires one frame pulse with the given setting and checks every output
    // cycle for span cycles. Optionally alters the setting mid-frame.
    task automatic run_frame(input bit md, input int code, input int span,
                             input int chg_at, input bit chg_md, input int chg_code,
                             input bit pre_chk, input string req);
        int s;
        int fp_cyc;
        int sd;
        int len;
        s = exp_offset(md, code);
        len = (span > 0) ? span : s + NQ + 5;
        mode_split = md;
        delay_code = 5'(code);
        fp_req_n++;
        @(negedge clk); #1;
        fp_cyc = acyc;
        for (int j = 0; j < len; j++) begin
            @(negedge clk); #1;
            sd = acyc - 1 - fp_cyc;
            if (sd == chg_at) begin
                mode_split = chg_md;
                delay_code = 5'(chg_code);
            end
            if (sd < s) begin
                if (pre_chk) chk(bit_valid == 1'b0, "R1 no valid before first bit", int'(bit_valid), 0);
            end else if (((sd - s) % 4) == 0) begin
                chk(bit_valid == 1'b1, "R6 strobe present", int'(bit_valid), 1);
                chk(int'(bit_index) == ((sd - s) / 4) % NB, "R5 bit index", int'(bit_index), ((sd - s) / 4) % NB);
                if (sd >= NQ)
                    chk(bit_out == line_val(fp_cyc + sd), {req, " R8 wrapped sample"}, int'(bit_out), int'(line_val(fp_cyc + sd)));
                else
                    chk(bit_out == line_val(fp_cyc + sd), {req, " sampled value"}, int'(bit_out), int'(line_val(fp_cyc + sd)));
            end else begin
                chk(bit_valid == 1'b0, "R6 strobe absent", int'(bit_valid), 0);
            end
        end
    endtask

    task automatic test_reset;
        rst = 1'b1;
        mode_split = 1'b0;
        delay_code = 5'd0;
        repeat (4) @(negedge clk);
        #1;
        chk(bit_valid == 1'b0, "R1 reset valid", int'(bit_valid), 0);
        chk(bit_out == 1'b0, "R1 reset data", int'(bit_out), 0);
        chk(bit_index == '0, "R1 reset index", int'(bit_index), 0);
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            chk(bit_valid == 1'b0, "R1 idle before frame pulse", int'(bit_valid), 0);
        end
    endtask

    task automatic test_first_frame_r3;
        run_frame(1'b0, 19, 0, -1, 1'b0, 0, 1'b1, "R3 code 19");
    endtask

    task automatic test_quarter_mode_r2;
        run_frame(1'b0, 0, 0, -1, 1'b0, 0, 1'b0, "R2 code 0");
        run_frame(1'b0, 1, 0, -1, 1'b0, 0, 1'b0, "R2 code 1");
        run_frame(1'b0, 31, 0, -1, 1'b0, 0, 1'b0, "R2 code 31");
    endtask

    task automatic test_split_mode_r4;
        run_frame(1'b1, 0, 0, -1, 1'b0, 0, 1'b0, "R4 phase 1/4");
        run_frame(1'b1, 3, 0, -1, 1'b0, 0, 1'b0, "R4 phase 4/4");
        run_frame(1'b1, 6, 0, -1, 1'b0, 0, 1'b0, "R4 one bit phase 3/4");
        run_frame(1'b1, 31, 0, -1, 1'b0, 0, 1'b0, "R4 seven bits phase 4/4");
    endtask

    task automatic test_midframe_change_r7;
        run_frame(1'b0, 5, 0, 12, 1'b1, 9, 1'b0, "R7 held setting");
        run_frame(1'b1, 9, 0, -1, 1'b0, 0, 1'b0, "R7 applied at next pulse");
    endtask

    task automatic test_realign_r9;
        run_frame(1'b0, 0, 30, -1, 1'b0, 0, 1'b0, "R9 partial frame");
        run_frame(1'b1, 2, 0, -1, 1'b0, 0, 1'b0, "R9 realigned frame");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1;
        mode_split = 1'b0;
        delay_code = 5'd0;
        test_reset();
        test_first_frame_r3();
        test_quarter_mode_r2();
        test_split_mode_r4();
        test_midframe_change_r7();
        test_realign_r9();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule